// File: doc/BRIEF.md
# External Interrupt Line Conditioner

The block takes three asynchronous external interrupt pins and turns each into a clean request for a parent interrupt controller that only understands active-high levels and rising edges. Every pin is brought into the clock domain by a two-stage synchronizer. The selected trigger condition is then detected: high level, low level, rising edge or falling edge. Low levels are inverted. Edge events of either polarity are held in a sticky pending flag, and that flag drives the output as a high level until software clears it.

Each line is configured by an 8-bit control field, reached through a plain 32-bit register port with byte enables. A build parameter selects one of two layouts. In the packed layout, all three fields share a single word at offset 0. In the split layout, each line has its own word at a fixed offset.

Top module: `xirq_cond`

## Requirements
- R1: After a synchronous reset every control field reads zero (disabled, level-high, no pending) and all three outputs are low.
- R2: Within a control field, bit 0 is the pending flag, bit 4 the sample-clock select (stored and read back only), bit 5 the enable, and bits 7:6 the trigger type. Bits 3:1 read as zero.
- R3: The trigger type is encoded as 00 level high, 01 level low, 10 rising edge, 11 falling edge.
- R4: In the packed layout (SHARED_LAYOUT=1), the word at offset 0 holds line 0 in bits 23:16, line 1 in 15:8 and line 2 in 7:0. A field is written only when its byte enable is set (bus_be[2], [1], [0] respectively), so the other fields are left unchanged. Writes to any other offset are ignored and reads of it return zero.
- R5: In the split layout (SHARED_LAYOUT=0), lines 0, 1 and 2 sit at byte offsets 0x000, 0x328 and 0x32C. Each uses bits 7:0, written under bus_be[0], and bits 31:8 read as zero.
- R6: With level-high type and enable set, the output equals the pin value from two clock edges earlier.
- R7: With level-low type and enable set, the output is the inverse of the pin value from two clock edges earlier.
- R8: With rising-edge type and enable set, a low-to-high pin transition sets pending at the third clock edge after the change. The output then follows pending.
- R9: With falling-edge type, a high-to-low transition sets pending with the same timing, and the output rises just as it does for a rising edge.
- R10: Writing 1 to bit 0 of a field clears that line's pending flag. Writing 0 there has no effect. An edge detected in the same cycle as the clear wins, and pending stays set.
- R11: Further edges while pending is already set merge into the same event, so a single clear drops the output.
- R12: With enable clear the output is low and no edge sets pending. Setting enable again while pending is held drives the output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin | input | 3 | Asynchronous external interrupt pins, one per line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_be | input | 4 | Write byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 3 | Normalized active-high requests to the parent controller |

## Verification
Some properties are checked by assertions on every cycle. A disabled line never asserts its output, and a disabled line with no pending flag cannot acquire one. Pending survives every cycle that carries no clear, and pending only rises under an edge type. The outputs are low in the cycle after reset. Other behaviour can only be shown by the bench's scenarios: synchronizer latency, inversion of low levels, merging of repeated edges, the write-0 no-op on pending, byte-lane isolation in the packed word, and agreement between the two layouts under random pin traffic with interleaved clears.

// File: rtl/xirq_pkg.sv
// Package: shared types, field bit positions and layout helpers for the
// external interrupt line conditioner. Assumes at most four lines in the
// packed layout (one byte lane each).
package xirq_pkg;

    localparam int FIELD_W   = 8;
    localparam int BIT_PEND  = 0;
    localparam int BIT_CKSEL = 4;
    localparam int BIT_EN    = 5;
    localparam int TRIG_LSB  = 6;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e trig;
        logic  en;
        logic  cksel;
        logic  pend;
    } line_cfg_t;

    // Byte offset of a line's own register in the split layout.
    function automatic logic [11:0] split_offset(input int idx);
        return (idx == 0) ? 12'h000 : 12'(12'h328 + 4 * (idx - 1));
    endfunction

    // Render a line's state as its 8-bit control field.
    function automatic logic [FIELD_W-1:0] field_of(input line_cfg_t c);
        return {c.trig, c.en, c.cksel, 3'b000, c.pend};
    endfunction

endpackage

// File: rtl/xirq_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a slow level that may be sampled bit by bit.
module xirq_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/xirq_line.sv
// One conditioned interrupt line: holds the control field, detects the
// selected level or edge on the synchronized pin, keeps the sticky edge
// pending flag and drives the normalized active-high request.
// Assumes pin_s is already synchronous to clk.
module xirq_line
    import xirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_s,
    input  logic               wr_hit,
    input  logic [FIELD_W-1:0] wr_byte,
    output line_cfg_t          cfg,
    output logic               clr_o,
    output logic               irq_o
);

    logic prev_q;
    logic rise, fall, edge_hit, level_val;

    // Previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    // Edge detection, gated by enable and the edge trigger types.
    always_comb begin
        rise     = pin_s & ~prev_q;
        fall     = ~pin_s & prev_q;
        edge_hit = 1'b0;
        if (cfg.en) begin
            case (cfg.trig)
                TRIG_RISE: edge_hit = rise;
                TRIG_FALL: edge_hit = fall;
                default:   edge_hit = 1'b0;
            endcase
        end
    end

    assign clr_o = wr_hit & wr_byte[BIT_PEND];

    // Control field storage; pending is write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_hit) begin
                cfg.trig  <= trig_e'(wr_byte[TRIG_LSB +: 2]);
                cfg.en    <= wr_byte[BIT_EN];
                cfg.cksel <= wr_byte[BIT_CKSEL];
            end
            if (edge_hit)   cfg.pend <= 1'b1;
            else if (clr_o) cfg.pend <= 1'b0;
        end
    end

    // Normalized output: level types pass or invert, edge types show pending.
    always_comb begin
        level_val = (cfg.trig == TRIG_LOW) ? ~pin_s : pin_s;
        irq_o     = cfg.en & (cfg.trig[1] ? cfg.pend : level_val);
    end

endmodule

// File: rtl/xirq_cond.sv
// External interrupt line conditioner top: synchronizes LINES pins,
// instantiates one line per pin and decodes the 32-bit register port in
// either the packed layout (one word at offset 0, line i in byte lane
// LINES-1-i) or the split layout (one word per line at split_offset(i)).
// Assumes LINES <= 4 when SHARED_LAYOUT is set.
module xirq_cond
    import xirq_pkg::*;
#(
    parameter int LINES         = 3,
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 32,
    parameter bit SHARED_LAYOUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LINES-1:0]  irq_out
);

    localparam int BYTES = DATA_W / 8;

    logic [LINES-1:0] pin_s;
    logic [LINES-1:0] line_hit, line_clr, line_en, line_pend, line_edge;
    logic [FIELD_W-1:0] line_byte [LINES];
    line_cfg_t          line_cfg  [LINES];
    logic [DATA_W-1:0]  rd_part   [LINES];

    xirq_sync #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_pin),
        .q_sync  (pin_s)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (SHARED_LAYOUT) begin : g_packed
            localparam int LANE = LINES - 1 - i;
            // Packed word: one byte lane per line at offset 0.
            always_comb begin
                line_hit[i]  = bus_wr && (bus_addr == '0) && bus_be[LANE];
                line_byte[i] = bus_wdata[LANE*8 +: 8];
                rd_part[i]   = '0;
                rd_part[i][LANE*8 +: 8] = field_of(line_cfg[i]);
                if (bus_addr != '0) rd_part[i] = '0;
            end
        end else begin : g_split
            localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(split_offset(i));
            // Split word: the line's own register, lane 0.
            always_comb begin
                line_hit[i]  = bus_wr && (bus_addr == OFFS) && bus_be[0];
                line_byte[i] = bus_wdata[7:0];
                rd_part[i]   = (bus_addr == OFFS) ?
                               {{(DATA_W-FIELD_W){1'b0}}, field_of(line_cfg[i])} : '0;
            end
        end

        xirq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_s[i]),
            .wr_hit  (line_hit[i]),
            .wr_byte (line_byte[i]),
            .cfg     (line_cfg[i]),
            .clr_o   (line_clr[i]),
            .irq_o   (irq_out[i])
        );

        assign line_en[i]   = line_cfg[i].en;
        assign line_pend[i] = line_cfg[i].pend;
        assign line_edge[i] = line_cfg[i].trig[1];
    end

    // Read-back: OR of the per-line contributions.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < LINES; i++) bus_rdata |= rd_part[i];
    end

    logic unused_bytes;
    assign unused_bytes = ^{BYTES};

endmodule

// File: rtl/xirq_cond_chk.sv
// Checker for xirq_cond: per-line enable gating and pending-flag rules,
// plus quiet outputs after reset. Bound to every instance of the top.
module xirq_cond_chk #(
    parameter int LINES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] irq_out,
    input logic [LINES-1:0] en_q,
    input logic [LINES-1:0] pend_q,
    input logic [LINES-1:0] clr_q,
    input logic [LINES-1:0] edge_q
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (irq_out == '0)); // R1

    for (genvar i = 0; i < LINES; i++) begin : g_chk
        AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[i] |-> !irq_out[i]); // R12

        AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[i] && !pend_q[i]) |=> !pend_q[i]); // R12

        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !clr_q[i]) |=> pend_q[i]); // R10

        AST_PEND_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[i]) |-> $past(edge_q[i])); // R8
    end

endmodule

bind xirq_cond xirq_cond_chk #(.LINES(LINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_out (irq_out),
    .en_q    (line_en),
    .pend_q  (line_pend),
    .clr_q   (line_clr),
    .edge_q  (line_edge)
);

// File: tb/xirq_cond_test.sv
// Bench: drives a packed-layout and a split-layout instance with the same
// pins and equivalent writes, and compares both against a behavioural
// model on every clock, plus explicit register and latency checks.
module xirq_cond_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [2:0]  pins  = '0;
    logic        sh_wr = 1'b0, pl_wr = 1'b0;
    logic [11:0] sh_addr = '0, pl_addr = '0;
    logic [3:0]  sh_be = '0, pl_be = '0;
    logic [31:0] sh_wdata = '0, pl_wdata = '0;
    logic [31:0] sh_rdata, pl_rdata;
    logic [2:0]  sh_irq, pl_irq;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    xirq_cond #(.SHARED_LAYOUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .irq_pin(pins), .bus_wr(sh_wr), .bus_addr(sh_addr),
        .bus_be(sh_be), .bus_wdata(sh_wdata), .bus_rdata(sh_rdata), .irq_out(sh_irq));

    xirq_cond #(.SHARED_LAYOUT(1'b0)) uut_pl (
        .clk(clk), .rst_n(rst_n), .irq_pin(pins), .bus_wr(pl_wr), .bus_addr(pl_addr),
        .bus_be(pl_be), .bus_wdata(pl_wdata), .bus_rdata(pl_rdata), .irq_out(pl_irq));

    // Offsets of the split layout, from R5.
    function automatic logic [11:0] offs(input int i);
        return (i == 0) ? 12'h000 : ((i == 1) ? 12'h328 : 12'h32C);
    endfunction

    // ---------------- behavioural model (index d: 0 packed, 1 split) ----------------
    bit [2:0] hist1, hist2, hist3;            // pin samples 1, 2, 3 edges old
    bit [1:0] m_ty [2][3];
    bit       m_en [2][3], m_ck [2][3], m_pd [2][3];

    always @(posedge clk) begin
        bit       wr, hit;
        bit [7:0] b;
        if (!rst_n) begin
            hist1 = '0; hist2 = '0; hist3 = '0;
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 3; i++) begin
                    m_ty[d][i] = 0; m_en[d][i] = 0; m_ck[d][i] = 0; m_pd[d][i] = 0;
                end
        end else begin
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 3; i++) begin
                    hit = m_en[d][i] &&
                          ((m_ty[d][i] == 2 && hist2[i] && !hist3[i]) ||
                           (m_ty[d][i] == 3 && !hist2[i] && hist3[i]));
                    wr = 0; b = 0;
                    if (d == 0) begin
                        if (sh_wr && sh_addr == 0 && sh_be[2-i]) begin
                            wr = 1; b = sh_wdata[8*(2-i) +: 8];
                        end
                    end else if (pl_wr && pl_be[0] && pl_addr == offs(i)) begin
                        wr = 1; b = pl_wdata[7:0];
                    end
                    if (wr) begin
                        m_ty[d][i] = b[7:6]; m_en[d][i] = b[5]; m_ck[d][i] = b[4];
                    end
                    if (hit)            m_pd[d][i] = 1;
                    else if (wr && b[0]) m_pd[d][i] = 0;
                end
            hist3 = hist2; hist2 = hist1; hist1 = pins;
        end
    end

    function automatic bit exp_out(input int d, input int i);
        bit lvl;
        lvl = (m_ty[d][i] == 1) ? !hist2[i] : hist2[i];
        return m_en[d][i] && (m_ty[d][i][1] ? m_pd[d][i] : lvl);
    endfunction

    function automatic logic [7:0] exp_field(input int d, input int i);
        return {m_ty[d][i], m_en[d][i], m_ck[d][i], 3'b000, m_pd[d][i]};
    endfunction

    // Per-clock output comparison for both instances.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 3; i++) begin
                checks += 2;
                if (sh_irq[i] !== exp_out(0, i)) begin
                    errors++;
                    $display("FAIL %s packed line%0d irq_out act=%0b exp=%0b", cur_req, i, sh_irq[i], exp_out(0, i));
                end
                if (pl_irq[i] !== exp_out(1, i)) begin
                    errors++;
                    $display("FAIL %s split line%0d irq_out act=%0b exp=%0b", cur_req, i, pl_irq[i], exp_out(1, i));
                end
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_line(input int i, input logic [7:0] b);
        @(negedge clk);
        sh_wr = 1; sh_addr = 0; sh_be = 4'(1 << (2 - i)); sh_wdata = 32'(b) << (8 * (2 - i));
        pl_wr = 1; pl_addr = offs(i); pl_be = 4'b0001; pl_wdata = {24'hFFFFFF, b};
        @(negedge clk);
        sh_wr = 0; pl_wr = 0; sh_be = 0; pl_be = 0;
    endtask

    task automatic sh_raw(input logic [11:0] a, input logic [3:0] be, input logic [31:0] dat);
        @(negedge clk);
        sh_wr = 1; sh_addr = a; sh_be = be; sh_wdata = dat;
        @(negedge clk);
        sh_wr = 0; sh_be = 0; sh_addr = 0;
    endtask

    task automatic chk_regs(input string req);
        @(negedge clk);
        #1;
        sh_addr = 0;
        #1;
        check(req, sh_rdata, {8'h00, exp_field(0, 0), exp_field(0, 1), exp_field(0, 2)}, "packed word");
        for (int i = 0; i < 3; i++) begin
            pl_addr = offs(i);
            #1;
            check(req, pl_rdata, {24'h0, exp_field(1, i)}, $sformatf("split line%0d", i));
        end
    endtask

    task automatic set_pins(input logic [2:0] v);
        @(negedge clk);
        pins = v;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        check("R1", {29'h0, sh_irq}, 32'h0, "packed irq after reset");
        check("R1", {29'h0, pl_irq}, 32'h0, "split irq after reset");
        chk_regs("R1");

        // R2, R3, R4, R5: configure line 0 level-high + cksel, line 1 level-low, line 2 rising.
        cur_req = "R2";
        wr_line(0, 8'h30);
        wr_line(1, 8'h60);
        wr_line(2, 8'hA0);
        chk_regs("R2");
        sh_addr = 0; #1;
        check("R4", sh_rdata, 32'h003060A0, "packed word literal");
        pl_addr = 12'h328; #1;
        check("R5", pl_rdata, 32'h00000060, "split line1 literal");

        // R6 latency: pin 0 rises, output high after two edges.
        cur_req = "R6";
        set_pins(3'b001);
        @(negedge clk);
        check("R6", {31'h0, sh_irq[0]}, 32'h0, "level-high one edge after pin");
        @(negedge clk);
        check("R6", {31'h0, sh_irq[0]}, 32'h1, "level-high two edges after pin");
        // R7: line 1 low level drives high while pin 1 low.
        cur_req = "R7";
        check("R7", {31'h0, sh_irq[1]}, 32'h1, "level-low with pin low");
        set_pins(3'b011);
        repeat (3) @(negedge clk);
        check("R7", {31'h0, pl_irq[1]}, 32'h0, "level-low with pin high");

        // R8: rising edge on line 2, output at third edge.
        cur_req = "R8";
        set_pins(3'b111);
        repeat (2) @(negedge clk);
        check("R8", {31'h0, sh_irq[2]}, 32'h0, "rise after two edges");
        @(negedge clk);
        check("R8", {31'h0, sh_irq[2]}, 32'h1, "rise after three edges");
        set_pins(3'b011);
        repeat (3) @(negedge clk);
        check("R8", {31'h0, pl_irq[2]}, 32'h1, "pending held after pin falls");

        // R10: write 0 to pending is no-op, then write 1 clears.
        cur_req = "R10";
        wr_line(2, 8'hA0);
        chk_regs("R10");
        check("R10", {31'h0, sh_irq[2]}, 32'h1, "write 0 keeps pending");
        wr_line(2, 8'hA1);
        @(negedge clk);
        check("R10", {31'h0, pl_irq[2]}, 32'h0, "write 1 clears pending");

        // R9 and R11: falling edges merge into one event.
        cur_req = "R9";
        wr_line(2, 8'hE0);
        set_pins(3'b111);
        set_pins(3'b011);
        repeat (4) @(negedge clk);
        check("R9", {31'h0, sh_irq[2]}, 32'h1, "falling edge output");
        cur_req = "R11";
        set_pins(3'b111);
        set_pins(3'b011);
        repeat (4) @(negedge clk);
        wr_line(2, 8'hE1);
        @(negedge clk);
        check("R11", {31'h0, sh_irq[2]}, 32'h0, "merged edges one clear");

        // R12: disable blocks output and detection; re-enable shows held pending.
        cur_req = "R12";
        set_pins(3'b111);
        set_pins(3'b011);
        repeat (4) @(negedge clk);
        wr_line(2, 8'hC0);
        @(negedge clk);
        check("R12", {31'h0, sh_irq[2]}, 32'h0, "disabled line with pending");
        set_pins(3'b111);
        set_pins(3'b011);
        repeat (4) @(negedge clk);
        chk_regs("R12");
        wr_line(2, 8'hC1);
        set_pins(3'b111);
        set_pins(3'b011);
        repeat (4) @(negedge clk);
        chk_regs("R12");
        check("R12", {31'h0, pl_irq[2]}, 32'h0, "disabled edge left no pending");
        wr_line(2, 8'hE0);
        set_pins(3'b111);
        set_pins(3'b011);
        repeat (4) @(negedge clk);
        wr_line(2, 8'hC0);
        wr_line(2, 8'hE0);
        @(negedge clk);
        check("R12", {31'h0, sh_irq[2]}, 32'h1, "re-enable with held pending");

        // R4: byte-lane isolation and ignored offsets in the packed layout.
        cur_req = "R4";
        sh_raw(12'h000, 4'b0010, 32'hFFFF40FF);
        sh_raw(12'h004, 4'b1111, 32'h00FFFFFF);
        sh_raw(12'h000, 4'b1000, 32'hFF000000);
        sh_addr = 12'h004; #1;
        check("R4", sh_rdata, 32'h0, "other offset reads zero");
        sh_addr = 0; #1;
        check("R4", sh_rdata[23:16], 32'h30, "line0 untouched by lane1 write");
        check("R4", sh_rdata[15:8], 32'h40, "line1 lane write");
        wr_line(1, 8'h60);
        chk_regs("R4");

        // R10/R11 random: edge lines with random pins and interleaved clears.
        cur_req = "R10";
        wr_line(0, 8'hA0);
        wr_line(1, 8'hE0);
        wr_line(2, 8'h60);
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            pins = 3'($urandom);
            if (($urandom % 5) == 0) begin
                int i;
                i = int'($urandom % 3);
                sh_wr = 1; sh_addr = 0; sh_be = 4'(1 << (2 - i));
                sh_wdata = 32'(exp_field(0, i) | 8'h01) << (8 * (2 - i));
                pl_wr = 1; pl_addr = offs(i); pl_be = 4'b0001;
                pl_wdata = {24'h0, exp_field(1, i) | 8'h01};
            end else begin
                sh_wr = 0; pl_wr = 0; sh_be = 0; pl_be = 0;
            end
        end
        sh_wr = 0; pl_wr = 0; sh_be = 0; pl_be = 0;
        chk_regs("R11");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule